// File: doc/BRIEF.md
# Three-Level Interrupt Aggregator

This block gathers a large set of interrupt lines into one host interrupt. Each line is sampled every clock and set up by software either as an edge detector or as a level follower. Two mask bits, one for each polarity, decide which transitions or levels count. Lines form blocks of eight, and blocks form masters of eight. Line `b*8+i` is bit `i` of block `b`, and block `m*8+j` is bit `j` of master `m`. The active status rolls up the tree into a root byte, and the root drives the host interrupt.

Software reaches the tree through a small byte-wide register port. The port has a 10-bit address, single-cycle read and write strobes, and read data that is registered one cycle after the read strobe. The registers sit at fixed offsets from a base address (default 0x1BB):

| Offset | Register |
|--------|----------|
| +0 | root |
| +1 to +4 | one summary register per master |
| +5 | block select |
| +6 | latched status of the selected block |
| +7 | write-only configuration byte for one line of the selected block |
| +8 | live input levels of the selected block |

The handler walks the tree from the root to the masters to the blocks. It acknowledges a line by writing the configuration byte with both masks and the clear bit set.

Top module: `irq_aggr_top`

## Requirements
- R1: After synchronous reset every line is in edge mode with both masks set, every latched status bit is 0, the root reads 0 and `irq_o` is 0.
- R2: A write to +5 stores all 8 data bits, and a read of +5 returns them. A read of +6 returns the latched status of the selected block, with bit `i` belonging to line `sel*8+i`. A select value of 32 or more reads status and live levels as 0, and configuration writes are ignored while it is selected.
- R3: A write to +7 with bit 7 = 1 configures the line with index bits 6:4 in the selected block. In that byte, bit 0 = level mode, bit 1 = mask falling edge or low level, and bit 2 = mask rising edge or high level. A write with bit 7 = 0 changes nothing.
- R4: In edge mode the input is compared with its value on the previous clock. A rise latches status when the rising mask is 0, and a fall latches status when the falling mask is 0. A latched bit stays set until it is cleared.
- R5: A committed configuration write with bit 3 = 1 clears that line's status on the same edge. The clear takes priority over an edge detected on that edge.
- R6: In level mode the status bit is registered every clock as (input AND NOT rising-mask) OR (NOT input AND NOT falling-mask). A clear forces it to 0 for that one cycle only.
- R7: A line with both masks set sets no new status bit. Any bit it still holds is left out of every summary and out of `irq_o`.
- R8: Bit `j` of the master register at +1+m is the OR of the unmasked status bits of block `m*8+j`.
- R9: Root bit `1+m` is the OR of master register `m`. Root bits 0 and 7:5 are 0. `irq_o` is the OR of the root.
- R10: A read of +8 returns the current, unlatched inputs of the selected block.
- R11: `rdata_o` is updated on the clock edge at which `rd_i` is sampled. Offset +7 and every address outside +0 to +8 read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | 256 | Interrupt source lines, synchronous to clk |
| addr_i | input | 10 | Register address |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Single-cycle write strobe |
| rd_i | input | 1 | Single-cycle read strobe |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Host interrupt |

## Verification
The assertions assume that the sources are already synchronous to `clk`, that `wr_i` and `rd_i` are never high together, and that reset is held for more than one cycle before its first release. The bench drives every input on the falling clock edge and issues one strobe at a time. It holds reset for five cycles. It flips only a few random source bits between register accesses, so edge and level behaviour are both exercised while each access still sees stable inputs.

// File: rtl/irq_aggr_pkg.sv
package irq_aggr_pkg;

    localparam int DATA_W        = 8;
    localparam int ADDR_W        = 10;
    localparam int LINE_IDX_W    = 3;
    localparam int LINES_PER_BLK = 1 << LINE_IDX_W;

    localparam int OFS_ROOT = 0;
    localparam int OFS_MST0 = 1;
    localparam int OFS_SEL  = 5;
    localparam int OFS_STAT = 6;
    localparam int OFS_CFG  = 7;
    localparam int OFS_LIVE = 8;

    typedef struct packed {
        logic lvl;
        logic mask_fall;
        logic mask_rise;
    } line_cfg_t;

    typedef struct packed {
        logic                  commit;
        logic [LINE_IDX_W-1:0] idx;
        logic                  clr;
        line_cfg_t             cfg;
    } cfg_cmd_t;

    localparam line_cfg_t CFG_RESET = '{lvl: 1'b0, mask_fall: 1'b1, mask_rise: 1'b1};

    function automatic cfg_cmd_t decode_cfg(input logic [DATA_W-1:0] b);
        cfg_cmd_t c;
        c.commit        = b[7];
        c.idx           = b[6:4];
        c.clr           = b[3];
        c.cfg.mask_rise = b[2];
        c.cfg.mask_fall = b[1];
        c.cfg.lvl       = b[0];
        return c;
    endfunction

endpackage

// File: rtl/irq_line.sv
module irq_line
    import irq_aggr_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      src_i,
    input  logic      we_i,
    input  line_cfg_t cfg_i,
    input  logic      clr_i,
    output logic      stat_o,
    output line_cfg_t cfg_o,
    output logic      live_o
);
    line_cfg_t cfg_q;
    logic      stat_q;
    logic      prev_q;
    logic      edge_hit;
    logic      lvl_hit;
    logic      stat_d;

    always_comb begin
        edge_hit = (src_i & ~prev_q & ~cfg_q.mask_rise) |
                   (~src_i & prev_q & ~cfg_q.mask_fall);
        lvl_hit  = (src_i & ~cfg_q.mask_rise) | (~src_i & ~cfg_q.mask_fall);
        stat_d   = cfg_q.lvl ? lvl_hit : (stat_q | edge_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= CFG_RESET;
            stat_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            prev_q <= src_i;
            if (we_i) cfg_q <= cfg_i;
            stat_q <= stat_d & ~(we_i & clr_i);
        end
    end

    assign stat_o = stat_q;
    assign cfg_o  = cfg_q;
    assign live_o = stat_q & ~(cfg_q.mask_fall & cfg_q.mask_rise);
endmodule

// File: rtl/irq_summary.sv
module irq_summary
    import irq_aggr_pkg::*;
#(
    parameter int N_SRC        = 256,
    parameter int BLKS_PER_MST = 8
) (
    input  logic [N_SRC-1:0]             live_i,
    output logic [N_SRC/LINES_PER_BLK-1:0] blk_sum_o,
    output logic [DATA_W-1:0]            root_o,
    output logic                         irq_o
);
    localparam int N_BLK = N_SRC / LINES_PER_BLK;
    localparam int N_MST = N_BLK / BLKS_PER_MST;

    logic [N_MST-1:0] mst_any;

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        assign blk_sum_o[b] = |live_i[b*LINES_PER_BLK +: LINES_PER_BLK];
    end

    for (genvar m = 0; m < N_MST; m++) begin : g_mst
        assign mst_any[m] = |blk_sum_o[m*BLKS_PER_MST +: BLKS_PER_MST];
    end

    always_comb begin
        root_o = '0;
        for (int m = 0; m < N_MST; m++) root_o[m+1] = mst_any[m];
    end

    assign irq_o = |root_o;
endmodule

// File: rtl/irq_regport.sv
module irq_regport
    import irq_aggr_pkg::*;
#(
    parameter int              N_SRC        = 256,
    parameter int              BLKS_PER_MST = 8,
    parameter logic [ADDR_W-1:0] BASE       = 10'h1BB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 wr_i,
    input  logic                 rd_i,
    input  logic [N_SRC-1:0]     stat_i,
    input  logic [N_SRC-1:0]     src_i,
    input  logic [N_SRC/LINES_PER_BLK-1:0] blk_sum_i,
    input  logic [DATA_W-1:0]    root_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 cfg_we_o,
    output logic [$clog2(N_SRC)-1:0] cfg_line_o,
    output line_cfg_t            cfg_val_o,
    output logic                 cfg_clr_o,
    output logic [DATA_W-1:0]    sel_o
);
    localparam int N_BLK  = N_SRC / LINES_PER_BLK;
    localparam int N_MST  = N_BLK / BLKS_PER_MST;
    localparam int BLK_W  = $clog2(N_BLK);
    localparam int LINE_W = $clog2(N_SRC);

    logic [DATA_W-1:0] sel_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_val;
    logic              sel_ok;
    logic [LINE_W-1:0] blk_base;
    cfg_cmd_t          cmd;

    assign sel_ok   = (sel_q < DATA_W'(N_BLK));
    assign blk_base = {sel_q[BLK_W-1:0], {LINE_IDX_W{1'b0}}};
    assign cmd      = decode_cfg(wdata_i);

    assign cfg_we_o   = wr_i && (addr_i == BASE + ADDR_W'(OFS_CFG)) && cmd.commit && sel_ok;
    assign cfg_line_o = {sel_q[BLK_W-1:0], cmd.idx};
    assign cfg_val_o  = cmd.cfg;
    assign cfg_clr_o  = cmd.clr;
    assign sel_o      = sel_q;

    always_comb begin
        rd_val = '0;
        if (addr_i == BASE + ADDR_W'(OFS_ROOT)) rd_val = root_i;
        for (int m = 0; m < N_MST; m++)
            if (addr_i == BASE + ADDR_W'(OFS_MST0 + m))
                rd_val = blk_sum_i[m*BLKS_PER_MST +: BLKS_PER_MST];
        if (addr_i == BASE + ADDR_W'(OFS_SEL)) rd_val = sel_q;
        if (addr_i == BASE + ADDR_W'(OFS_STAT) && sel_ok) rd_val = stat_i[blk_base +: LINES_PER_BLK];
        if (addr_i == BASE + ADDR_W'(OFS_LIVE) && sel_ok) rd_val = src_i[blk_base +: LINES_PER_BLK];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            rdata_q <= '0;
        end else begin
            if (wr_i && addr_i == BASE + ADDR_W'(OFS_SEL)) sel_q <= wdata_i;
            if (rd_i) rdata_q <= rd_val;
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/irq_aggr_top.sv
module irq_aggr_top
    import irq_aggr_pkg::*;
#(
    parameter int                N_SOURCES    = 256,
    parameter int                BLKS_PER_MST = 8,
    parameter logic [ADDR_W-1:0] BASE_ADDR    = 10'h1BB
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N_SOURCES-1:0] src_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 wr_i,
    input  logic                 rd_i,
    output logic [DATA_W-1:0]    rdata_o,
    output logic                 irq_o
);
    localparam int N_BLK  = N_SOURCES / LINES_PER_BLK;
    localparam int LINE_W = $clog2(N_SOURCES);

    logic [N_SOURCES-1:0]            stat_all;
    logic [N_SOURCES-1:0]            live_all;
    line_cfg_t [N_SOURCES-1:0]       cfg_all;
    logic [N_BLK-1:0]                blk_sum;
    logic [DATA_W-1:0]               root;
    logic [DATA_W-1:0]               blk_sel;
    logic                            cfg_we;
    logic [LINE_W-1:0]               cfg_line;
    line_cfg_t                       cfg_val;
    logic                            cfg_clr;

    for (genvar i = 0; i < N_SOURCES; i++) begin : g_line
        irq_line u_line (
            .clk    (clk),
            .rst    (rst),
            .src_i  (src_i[i]),
            .we_i   (cfg_we && (cfg_line == LINE_W'(i))),
            .cfg_i  (cfg_val),
            .clr_i  (cfg_clr),
            .stat_o (stat_all[i]),
            .cfg_o  (cfg_all[i]),
            .live_o (live_all[i])
        );
    end

    irq_summary #(.N_SRC(N_SOURCES), .BLKS_PER_MST(BLKS_PER_MST)) u_sum (
        .live_i    (live_all),
        .blk_sum_o (blk_sum),
        .root_o    (root),
        .irq_o     (irq_o)
    );

    irq_regport #(.N_SRC(N_SOURCES), .BLKS_PER_MST(BLKS_PER_MST), .BASE(BASE_ADDR)) u_port (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .wr_i       (wr_i),
        .rd_i       (rd_i),
        .stat_i     (stat_all),
        .src_i      (src_i),
        .blk_sum_i  (blk_sum),
        .root_i     (root),
        .rdata_o    (rdata_o),
        .cfg_we_o   (cfg_we),
        .cfg_line_o (cfg_line),
        .cfg_val_o  (cfg_val),
        .cfg_clr_o  (cfg_clr),
        .sel_o      (blk_sel)
    );
endmodule

// File: rtl/irq_aggr_chk.sv
module irq_aggr_chk
    import irq_aggr_pkg::*;
#(
    parameter int                N_SRC = 256,
    parameter logic [ADDR_W-1:0] BASE  = 10'h1BB
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [ADDR_W-1:0]     addr_i,
    input  logic [DATA_W-1:0]     wdata_i,
    input  logic [DATA_W-1:0]     rdata_o,
    input  logic                  irq_o,
    input  logic [N_SRC-1:0]      stat,
    input  line_cfg_t [N_SRC-1:0] cfg,
    input  logic [DATA_W-1:0]     sel
);
    localparam int N_BLK  = N_SRC / LINES_PER_BLK;
    localparam int BLK_W  = $clog2(N_BLK);
    localparam int LINE_W = $clog2(N_SRC);

    logic [N_SRC-1:0]  full_mask;
    logic [LINE_W-1:0] ack_line;
    logic              ack_wr;
    logic              cfg_noncommit;
    logic              in_window;

    always_comb begin
        for (int i = 0; i < N_SRC; i++) full_mask[i] = cfg[i].mask_fall & cfg[i].mask_rise;
    end

    assign ack_line      = {sel[BLK_W-1:0], wdata_i[6:4]};
    assign ack_wr        = wr_i && addr_i == BASE + ADDR_W'(OFS_CFG) && wdata_i[7] && wdata_i[3]
                           && sel < DATA_W'(N_BLK);
    assign cfg_noncommit = wr_i && addr_i == BASE + ADDR_W'(OFS_CFG) && !wdata_i[7];
    assign in_window     = addr_i >= BASE && addr_i <= BASE + ADDR_W'(OFS_LIVE)
                           && addr_i != BASE + ADDR_W'(OFS_CFG);

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!irq_o && stat == '0));

    p_cfg_ignored_r3: assert property (@(posedge clk) disable iff (rst)
        cfg_noncommit |=> $stable(cfg));

    p_clear_wins_r5: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> !stat[$past(ack_line)]);

    p_masked_no_rise_r7: assert property (@(posedge clk) disable iff (rst)
        !$fell(rst) |-> ((stat & ~$past(stat) & $past(full_mask)) == '0));

    p_irq_tree_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o == |(stat & ~full_mask));

    p_read_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_i && !in_window) |=> rdata_o == '0);
endmodule

bind irq_aggr_top irq_aggr_chk #(.N_SRC(N_SOURCES), .BASE(BASE_ADDR)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .irq_o   (irq_o),
    .stat    (stat_all),
    .cfg     (cfg_all),
    .sel     (blk_sel)
);

// File: tb/irq_aggr_top_tb.sv
module irq_aggr_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 256;
    localparam int NB = 32;
    localparam logic [9:0] BASE = 10'h1BB;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [NS-1:0] src = '0;
    logic [9:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] rdata;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic m_lvl [NS];
    logic m_mf  [NS];
    logic m_mr  [NS];
    logic m_st  [NS];
    logic m_pv  [NS];
    logic [7:0] m_sel;

    irq_aggr_top dut_i (
        .clk(clk), .rst(rst), .src_i(src), .addr_i(addr), .wdata_i(wdata),
        .wr_i(wr), .rd_i(rd), .rdata_o(rdata), .irq_o(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NS; i++) begin
                m_lvl[i] = 0; m_mf[i] = 1; m_mr[i] = 1; m_st[i] = 0; m_pv[i] = 0;
            end
            m_sel = '0;
        end else begin
            for (int i = 0; i < NS; i++) begin
                logic e, l;
                e = (src[i] & ~m_pv[i] & ~m_mr[i]) | (~src[i] & m_pv[i] & ~m_mf[i]);
                l = (src[i] & ~m_mr[i]) | (~src[i] & ~m_mf[i]);
                m_st[i] = m_lvl[i] ? l : (m_st[i] | e);
                m_pv[i] = src[i];
            end
            if (wr && addr == BASE + 10'd7 && wdata[7] && m_sel < 8'(NB)) begin
                int ln;
                ln = int'(m_sel) * 8 + int'(wdata[6:4]);
                m_lvl[ln] = wdata[0]; m_mf[ln] = wdata[1]; m_mr[ln] = wdata[2];
                if (wdata[3]) m_st[ln] = 0;
            end
            if (wr && addr == BASE + 10'd5) m_sel = wdata;
        end
    end

    function automatic logic blk_any(int b);
        logic r = 0;
        for (int i = 0; i < 8; i++) r |= m_st[b*8+i] & ~(m_mf[b*8+i] & m_mr[b*8+i]);
        return r;
    endfunction

    function automatic logic [7:0] exp_root();
        logic [7:0] r = '0;
        for (int m = 0; m < 4; m++)
            for (int j = 0; j < 8; j++) r[m+1] |= blk_any(m*8+j);
        return r;
    endfunction

    function automatic logic [7:0] exp_read(logic [9:0] a);
        logic [7:0] r = '0;
        if (a == BASE) r = exp_root();
        else if (a >= BASE + 10'd1 && a <= BASE + 10'd4) begin
            for (int j = 0; j < 8; j++) r[j] = blk_any(int'(a - BASE - 10'd1) * 8 + j);
        end else if (a == BASE + 10'd5) r = m_sel;
        else if (a == BASE + 10'd6 && m_sel < 8'(NB)) begin
            for (int j = 0; j < 8; j++) r[j] = m_st[int'(m_sel)*8+j];
        end else if (a == BASE + 10'd8 && m_sel < 8'(NB)) begin
            for (int j = 0; j < 8; j++) r[j] = src[int'(m_sel)*8+j];
        end
        return r;
    endfunction

    task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic reg_wr(logic [9:0] a, logic [7:0] d);
        @(negedge clk);
        wr = 1; addr = a; wdata = d;
        @(negedge clk);
        wr = 0;
    endtask

    task automatic reg_rd(logic [9:0] a, string tag);
        logic [7:0] e;
        @(negedge clk);
        rd = 1; addr = a;
        e = exp_read(a);
        @(negedge clk);
        rd = 0;
        check8(tag, rdata, e);
    endtask

    task automatic chk_irq(string tag);
        @(negedge clk);
        check8(tag, {7'd0, irq}, {7'd0, exp_root() != 0});
    endtask

    task automatic set_src(int i, logic v);
        @(negedge clk);
        src[i] = v;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 0;
        // R1 reset state
        check8("R1 irq after reset", {7'd0, irq}, 8'd0);
        reg_rd(BASE, "R1 root after reset");
        for (int m = 1; m <= 4; m++) reg_rd(BASE + 10'(m), "R1 master after reset");
        // R2 select read back
        reg_wr(BASE + 10'd5, 8'd3);
        reg_rd(BASE + 10'd5, "R2 select readback");
        // R4 rising edge on line 5 of block 3 (line 29)
        reg_wr(BASE + 10'd7, 8'hD2);
        set_src(29, 1);
        reg_rd(BASE + 10'd6, "R4 rising edge latched");
        reg_rd(BASE + 10'd1, "R8 master summary");
        reg_rd(BASE, "R9 root summary");
        chk_irq("R9 irq asserted");
        set_src(29, 0);
        reg_rd(BASE + 10'd6, "R4 stays latched after fall");
        // R5 clear
        reg_wr(BASE + 10'd7, 8'hDA);
        reg_rd(BASE + 10'd6, "R5 cleared");
        chk_irq("R5 irq dropped");
        // R5 clear on the same edge as a new edge
        @(negedge clk);
        src[29] = 1; wr = 1; addr = BASE + 10'd7; wdata = 8'hDA;
        @(negedge clk);
        wr = 0;
        reg_rd(BASE + 10'd6, "R5 clear beats edge");
        src[29] = 0;
        // R3 non-committed write ignored
        reg_wr(BASE + 10'd7, 8'h60);
        set_src(30, 1);
        set_src(30, 0);
        reg_rd(BASE + 10'd6, "R3 write without commit ignored");
        // R4 falling edge detection on line 30
        reg_wr(BASE + 10'd7, 8'hE4);
        set_src(30, 1);
        set_src(30, 0);
        reg_rd(BASE + 10'd6, "R4 falling edge latched");
        reg_wr(BASE + 10'd7, 8'hEE);
        // R6 level high on line 24
        reg_wr(BASE + 10'd7, 8'h83);
        set_src(24, 1);
        reg_rd(BASE + 10'd6, "R6 level high active");
        set_src(24, 0);
        reg_rd(BASE + 10'd6, "R6 level high follows input");
        // R6 level low on line 25
        reg_wr(BASE + 10'd7, 8'h95);
        reg_rd(BASE + 10'd6, "R6 level low active");
        reg_wr(BASE + 10'd7, 8'h9D);
        reg_rd(BASE + 10'd6, "R6 clear lasts one cycle");
        reg_rd(BASE + 10'd6, "R6 level low returns");
        reg_wr(BASE + 10'd7, 8'h96);
        reg_wr(BASE + 10'd7, 8'h86);
        // R7 latched then fully masked without clear
        reg_wr(BASE + 10'd7, 8'hD2);
        set_src(29, 1);
        reg_wr(BASE + 10'd7, 8'hD6);
        reg_rd(BASE + 10'd6, "R7 status kept while masked");
        reg_rd(BASE + 10'd1, "R7 masked line out of master");
        chk_irq("R7 masked line out of irq");
        set_src(29, 0);
        set_src(29, 1);
        reg_rd(BASE + 10'd6, "R7 masked line sets nothing");
        reg_wr(BASE + 10'd7, 8'hDE);
        // R10 live levels
        src[26] = 1;
        reg_rd(BASE + 10'd8, "R10 live levels");
        // R9 last master, block 31 line 7
        reg_wr(BASE + 10'd5, 8'd31);
        reg_wr(BASE + 10'd7, 8'hF2);
        set_src(255, 1);
        reg_rd(BASE, "R9 root top master");
        reg_rd(BASE + 10'd4, "R8 master four");
        // R2 out-of-range select
        reg_wr(BASE + 10'd5, 8'd40);
        reg_rd(BASE + 10'd6, "R2 out-of-range status zero");
        reg_rd(BASE + 10'd8, "R2 out-of-range live zero");
        reg_wr(BASE + 10'd7, 8'hFA);
        reg_rd(BASE, "R2 out-of-range config ignored");
        // R11 unmapped and config reads
        reg_rd(10'h000, "R11 unmapped reads zero");
        reg_rd(BASE + 10'd7, "R11 config reads zero");
        reg_rd(BASE + 10'd9, "R11 past window zero");

        // random phase
        void'($urandom(32'h5EED_1234));
        for (int it = 0; it < 2500; it++) begin
            int k;
            k = $urandom_range(0, 9);
            if (k < 3) begin
                @(negedge clk);
                for (int f = 0; f < 4; f++) src[$urandom_range(0, NS-1)] ^= 1'b1;
            end else if (k < 5) begin
                logic [7:0] d;
                d = 8'($urandom);
                if ($urandom_range(0, 3) != 0) d[7] = 1'b1;
                reg_wr(BASE + 10'd7, d);
            end else if (k == 5) begin
                reg_wr(BASE + 10'd5, ($urandom_range(0, 15) == 0) ? 8'($urandom) : 8'($urandom_range(0, NB-1)));
            end else if (k < 9) begin
                reg_rd(BASE + 10'($urandom_range(0, 9)), "R8 random register read");
            end else begin
                chk_irq("R9 random irq");
            end
        end
        finish_run();
    end
endmodule